// File: doc/BRIEF.md
# Interrupt Gate Descriptor Fetch and Check

This block turns an interrupt vector number into a validated handler target. It keeps a table register made of a 32-bit linear base address and a 16-bit inclusive byte limit. On each request it checks that the vector's 8-byte gate descriptor lies inside the table. It then reads that descriptor from memory as two 32-bit words, decodes the fields and checks the gate type, the storage-segment bit, the present bit and the caller's privilege. It returns the handler selector, the reassembled 32-bit offset, a gate kind code and an encoded fault cause.

A controller loads the table register once and then issues requests carrying a vector and the caller's ring number. The memory port is synchronous: read data arrives one cycle after `mem_rd_en`. The sequencer has five named states. IDLE accepts a request; a limit fault goes straight from IDLE to DONE, and otherwise IDLE goes to READ_LO. READ_LO issues the low-word read. READ_HI issues the high-word read and captures the low word. CHECK decodes both words and registers the result. DONE holds the response until `rsp_ack`, then returns to IDLE.

Top module: `idt_gate_fetch`

## Requirements
- R1: Asserting `tbl_load` stores `tbl_data[15:0]` as the limit and `tbl_data[47:16]` as the base. Every request accepted after the load uses these values.
- R2: A request faults with cause 1 (limit) when vector*8+7 exceeds the limit. It is accepted when vector*8+7 is equal to or below the limit, and limits above 2047 are legal.
- R3: A limit fault issues no memory reads. Any other request issues exactly two reads, at base+vector*8 and then base+vector*8+4, with all sums taken modulo 2^32.
- R4: In the low word, bits 15:0 are offset bits 15:0 and bits 31:16 are the selector. In the high word, bits 7:0 are the reserved byte, bits 15:8 are the flags and bits 31:16 are offset bits 31:16. `rsp_offset` is the high half placed above the low half.
- R5: `rsp_kind` gives the gate kind from flags bits 3:0: type 0x5 gives 1 (32-bit task), 0x6 gives 2 (16-bit interrupt), 0x7 gives 3 (16-bit trap), 0xE gives 4 (32-bit interrupt) and 0xF gives 5 (32-bit trap).
- R6: Any other type value, or a nonzero reserved byte, faults with cause 2 (type).
- R7: An interrupt or trap gate with flags bit 4 set faults with cause 3 (storage). A task gate with bit 4 set does not fault for that bit.
- R8: A descriptor with flags bit 7 (present) clear faults with cause 4 (present).
- R9: A request faults with cause 5 (privilege) when the caller ring is greater than flags bits 6:5. It is allowed when the ring is equal or lower.
- R10: When several faults apply, only the first is reported, in the order limit, type, storage, present, privilege. Cause 0 means no fault.
- R11: `rsp_fault` is high exactly when the cause is nonzero. On a fault, `rsp_selector`, `rsp_offset` and `rsp_kind` are zero.
- R12: After reset and between requests, `req_ready` is high and `rsp_valid` is low. A response stays valid and unchanged until `rsp_ack`. `req_ready` and `rsp_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_load | input | 1 | Write strobe for the table register |
| tbl_data | input | 48 | Limit in bits 15:0, base in bits 47:16 |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vector | input | 8 | Interrupt vector number |
| req_ring | input | 2 | Caller privilege ring |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Result consumed |
| rsp_selector | output | 16 | Handler segment selector |
| rsp_offset | output | 32 | Handler offset |
| rsp_kind | output | 3 | Gate kind code |
| rsp_fault | output | 1 | Request rejected |
| rsp_cause | output | 3 | Fault cause code |

## Verification
The bench aims at the exact inclusive limit edge, one vector on each side of it. An off-by-one compare would either reject the last entry or read past the table, and would then report a decoded gate where a limit fault belongs. It combines several faults in one descriptor to expose a wrong priority order. It uses a task gate with the storage bit set, to catch a design that applies the storage check to every gate type. It places the base near the top of the address space, where an address adder that does not wrap would fetch from the wrong place. It also delays acknowledgements to catch a response that changes or drops before it is consumed.

// File: rtl/idt_pkg.sv
package idt_pkg;

    localparam int HALF_W = 32;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_LIMIT   = 3'd1,
        CAUSE_TYPE    = 3'd2,
        CAUSE_STORAGE = 3'd3,
        CAUSE_PRESENT = 3'd4,
        CAUSE_PRIV    = 3'd5
    } fault_cause_t;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_TASK32 = 3'd1,
        KIND_INT16  = 3'd2,
        KIND_TRAP16 = 3'd3,
        KIND_INT32  = 3'd4,
        KIND_TRAP32 = 3'd5
    } gate_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_LO,
        ST_READ_HI,
        ST_CHECK,
        ST_DONE
    } fetch_state_t;

    typedef struct packed {
        logic [15:0]  selector;
        logic [31:0]  offset;
        gate_kind_t   kind;
        fault_cause_t cause;
    } gate_result_t;

endpackage

// File: rtl/idt_addr_calc.sv
module idt_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 16,
    parameter int VEC_W      = 8,
    parameter int DESC_BYTES = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [VEC_W-1:0]   vector,
    output logic [ADDR_W-1:0]  lo_addr,
    output logic [ADDR_W-1:0]  hi_addr,
    output logic               out_of_bounds
);
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);

    logic [ADDR_W-1:0] rel_first;
    logic [ADDR_W-1:0] rel_last;

    assign rel_first     = ADDR_W'(vector) << DESC_SHIFT;
    assign rel_last      = rel_first + ADDR_W'(DESC_BYTES - 1);
    assign out_of_bounds = rel_last > ADDR_W'(limit);
    assign lo_addr       = base + rel_first;
    assign hi_addr       = lo_addr + ADDR_W'(DESC_BYTES / 2);

endmodule

// File: rtl/idt_gate_decode.sv
module idt_gate_decode
    import idt_pkg::*;
#(
    parameter int RING_W = 2
) (
    input  logic [HALF_W-1:0] lo_word,
    input  logic [HALF_W-1:0] hi_word,
    input  logic [RING_W-1:0] ring,
    output gate_result_t      result
);
    logic [7:0]   flags;
    logic [7:0]   rsvd;
    gate_kind_t   kind;
    logic         is_int_trap;
    fault_cause_t cause;

    assign flags = hi_word[15:8];
    assign rsvd  = hi_word[7:0];

    always_comb begin
        unique case (flags[3:0])
            4'h5:    kind = KIND_TASK32;
            4'h6:    kind = KIND_INT16;
            4'h7:    kind = KIND_TRAP16;
            4'hE:    kind = KIND_INT32;
            4'hF:    kind = KIND_TRAP32;
            default: kind = KIND_NONE;
        endcase
    end

    assign is_int_trap = (kind != KIND_NONE) && (kind != KIND_TASK32);

    always_comb begin
        if (kind == KIND_NONE || rsvd != 8'h00)
            cause = CAUSE_TYPE;
        else if (is_int_trap && flags[4])
            cause = CAUSE_STORAGE;
        else if (!flags[7])
            cause = CAUSE_PRESENT;
        else if (RING_W'(ring) > RING_W'(flags[6:5]))
            cause = CAUSE_PRIV;
        else
            cause = CAUSE_NONE;
    end

    always_comb begin
        if (cause == CAUSE_NONE) begin
            result.selector = lo_word[31:16];
            result.offset   = {hi_word[31:16], lo_word[15:0]};
            result.kind     = kind;
        end else begin
            result.selector = '0;
            result.offset   = '0;
            result.kind     = KIND_NONE;
        end
        result.cause = cause;
    end

endmodule

// File: rtl/idt_gate_fetch.sv
module idt_gate_fetch
    import idt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16,
    parameter int VEC_W   = 8,
    parameter int RING_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbl_load,
    input  logic [LIMIT_W+ADDR_W-1:0]  tbl_data,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VEC_W-1:0]           req_vector,
    input  logic [RING_W-1:0]          req_ring,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_rd_addr,
    input  logic [HALF_W-1:0]          mem_rd_data,
    output logic                       rsp_valid,
    input  logic                       rsp_ack,
    output logic [15:0]                rsp_selector,
    output logic [31:0]                rsp_offset,
    output logic [2:0]                 rsp_kind,
    output logic                       rsp_fault,
    output logic [2:0]                 rsp_cause
);
    fetch_state_t       state_q, state_d;
    logic [ADDR_W-1:0]  base_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [VEC_W-1:0]   vec_q;
    logic [RING_W-1:0]  ring_q;
    logic [HALF_W-1:0]  lo_q;
    gate_result_t       res_q;
    gate_result_t       dec_res;
    logic [VEC_W-1:0]   calc_vec;
    logic [ADDR_W-1:0]  lo_addr, hi_addr;
    logic               oob;
    logic               accept;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign calc_vec = (state_q == ST_IDLE) ? req_vector : vec_q;

    idt_addr_calc #(
        .ADDR_W    (ADDR_W),
        .LIMIT_W   (LIMIT_W),
        .VEC_W     (VEC_W),
        .DESC_BYTES(8)
    ) u_addr (
        .base         (base_q),
        .limit        (limit_q),
        .vector       (calc_vec),
        .lo_addr      (lo_addr),
        .hi_addr      (hi_addr),
        .out_of_bounds(oob)
    );

    idt_gate_decode #(
        .RING_W(RING_W)
    ) u_dec (
        .lo_word(lo_q),
        .hi_word(mem_rd_data),
        .ring   (ring_q),
        .result (dec_res)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = oob ? ST_DONE : ST_READ_LO;
            ST_READ_LO: state_d = ST_READ_HI;
            ST_READ_HI: state_d = ST_CHECK;
            ST_CHECK:   state_d = ST_DONE;
            ST_DONE:    if (rsp_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            vec_q   <= '0;
            ring_q  <= '0;
            lo_q    <= '0;
            res_q   <= '0;
        end else begin
            if (tbl_load) begin
                limit_q <= tbl_data[LIMIT_W-1:0];
                base_q  <= tbl_data[LIMIT_W+ADDR_W-1:LIMIT_W];
            end
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    vec_q  <= req_vector;
                    ring_q <= req_ring;
                    if (oob) begin
                        res_q.selector <= '0;
                        res_q.offset   <= '0;
                        res_q.kind     <= KIND_NONE;
                        res_q.cause    <= CAUSE_LIMIT;
                    end
                end
                ST_READ_HI: lo_q  <= mem_rd_data;
                ST_CHECK:   res_q <= dec_res;
                default: ;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_en    = (state_q == ST_READ_LO) || (state_q == ST_READ_HI);
    assign mem_rd_addr  = (state_q == ST_READ_HI) ? hi_addr : lo_addr;
    assign rsp_valid    = (state_q == ST_DONE);
    assign rsp_selector = res_q.selector;
    assign rsp_offset   = res_q.offset;
    assign rsp_kind     = res_q.kind;
    assign rsp_cause    = res_q.cause;
    assign rsp_fault    = (res_q.cause != CAUSE_NONE);

endmodule

// File: rtl/idt_gate_fetch_chk.sv
module idt_gate_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_rd_en,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic        rsp_ack,
    input logic [15:0] rsp_selector,
    input logic [31:0] rsp_offset,
    input logic [2:0]  rsp_kind,
    input logic        rsp_fault,
    input logic [2:0]  rsp_cause
);
    // R12
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_selector) &&
            $stable(rsp_offset) && $stable(rsp_kind) && $stable(rsp_cause)));

    // R12
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R12
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |=> (!rsp_valid && req_ready));

    // R3
    read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + 32'd4));

    // R3
    read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

    // R3
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (!req_ready && !rsp_valid));

    // R11
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_kind == 3'd0 && rsp_selector == 16'd0 &&
            rsp_offset == 32'd0 && rsp_cause != 3'd0));

endmodule

bind idt_gate_fetch idt_gate_fetch_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ack     (rsp_ack),
    .rsp_selector(rsp_selector),
    .rsp_offset  (rsp_offset),
    .rsp_kind    (rsp_kind),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause)
);

// File: tb/idt_gate_fetch_tb_top.sv
module idt_gate_fetch_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_load = 1'b0;
    logic [47:0] tbl_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic [1:0]  req_ring = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic [15:0] rsp_selector;
    logic [31:0] rsp_offset;
    logic [2:0]  rsp_kind;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;

    always #(CLK_PERIOD / 2) clk = ~clk;

    idt_gate_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_load(tbl_load), .tbl_data(tbl_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
        .req_ring(req_ring), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_selector(rsp_selector), .rsp_offset(rsp_offset), .rsp_kind(rsp_kind),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] tb_base  = '0;
    logic [15:0] tb_limit = '0;

    typedef struct {
        logic [15:0] sel;
        logic [31:0] off;
        logic [2:0]  kind;
        logic [2:0]  cause;
        int          reads;
        logic [31:0] addr;
        int          hold;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic put_desc(input logic [7:0] vec, input logic [15:0] sel,
                            input logic [31:0] off, input logic [7:0] rsv,
                            input logic [7:0] flags);
        logic [31:0] a;
        a = tb_base + {21'd0, vec, 3'b000};
        mem[a]         = {sel, off[15:0]};
        mem[a + 32'd4] = {off[31:16], flags, rsv};
    endtask

    task automatic load_tbl(input logic [31:0] base, input logic [15:0] limit);
        @(negedge clk);
        tbl_load = 1'b1;
        tbl_data = {base, limit};
        @(negedge clk);
        tbl_load = 1'b0;
        tb_base  = base;
        tb_limit = limit;
    endtask

    function automatic exp_t model(input logic [7:0] vec, input logic [1:0] ring);
        exp_t e;
        logic [31:0] rel, lo, hi;
        logic [7:0]  fl;
        logic [2:0]  k;
        bool_dummy: begin end
        rel    = {21'd0, vec, 3'b000};
        e.addr = tb_base + rel;
        e.sel = '0; e.off = '0; e.kind = '0; e.cause = '0; e.reads = 2;
        e.hold = int'(vec % 4); e.req = "";
        if (rel + 32'd7 > {16'd0, tb_limit}) begin
            e.cause = 3'd1; e.reads = 0;
            return e;
        end
        lo = rdw(e.addr);
        hi = rdw(e.addr + 32'd4);
        fl = hi[15:8];
        case (fl[3:0])
            4'h5: k = 3'd1;
            4'h6: k = 3'd2;
            4'h7: k = 3'd3;
            4'hE: k = 3'd4;
            4'hF: k = 3'd5;
            default: k = 3'd0;
        endcase
        if (k == 3'd0 || hi[7:0] != 8'h00) e.cause = 3'd2;
        else if (k != 3'd1 && fl[4]) e.cause = 3'd3;
        else if (!fl[7]) e.cause = 3'd4;
        else if (ring > fl[6:5]) e.cause = 3'd5;
        if (e.cause == 3'd0) begin
            e.sel = lo[31:16];
            e.off = {hi[31:16], lo[15:0]};
            e.kind = k;
        end
        return e;
    endfunction

    task automatic run_req(input logic [7:0] vec, input logic [1:0] ring, input string req);
        exp_t e;
        e = model(vec, ring);
        e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_vector = vec;
        req_ring   = ring;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin : monitor
        int rd_cnt;
        logic [31:0] first_addr;
        exp_t e;
        logic [15:0] s0; logic [31:0] o0; logic [2:0] k0, c0;
        rd_cnt = 0;
        first_addr = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_cnt = 0;
            end else begin
                if (mem_rd_en) begin
                    if (rd_cnt == 0) first_addr = mem_rd_addr;
                    rd_cnt++;
                end
                if (rsp_valid && !rsp_ack) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R12", "unexpected response", 32'd1, 32'd0);
                    end else begin
                        e = sb_q.pop_front();
                        check(rsp_cause == e.cause, e.req, "cause", 32'(rsp_cause), 32'(e.cause));
                        check(rsp_fault == (e.cause != 3'd0), "R11", "fault flag",
                              32'(rsp_fault), 32'(e.cause != 3'd0));
                        check(rsp_selector == e.sel, e.req, "selector", 32'(rsp_selector), 32'(e.sel));
                        check(rsp_offset == e.off, e.req, "offset", rsp_offset, e.off);
                        check(rsp_kind == e.kind, e.req, "kind", 32'(rsp_kind), 32'(e.kind));
                        check(rd_cnt == e.reads, "R3", "read count", 32'(rd_cnt), 32'(e.reads));
                        if (e.reads != 0)
                            check(first_addr == e.addr, "R3", "read address", first_addr, e.addr);
                        s0 = rsp_selector; o0 = rsp_offset; k0 = rsp_kind; c0 = rsp_cause;
                        for (int i = 0; i < e.hold; i++) @(negedge clk);
                        check(rsp_valid && s0 == rsp_selector && o0 == rsp_offset &&
                              k0 == rsp_kind && c0 == rsp_cause, "R12", "held response",
                              32'(rsp_valid), 32'd1);
                        rsp_ack = 1'b1;
                        @(negedge clk);
                        rsp_ack = 1'b0;
                        check(!rsp_valid && req_ready, "R12", "idle after ack",
                              {30'd0, rsp_valid, req_ready}, 32'd1);
                        rd_cnt = 0;
                    end
                end
            end
        end
    end

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready && !rsp_valid && !mem_rd_en, "R12", "reset state",
              {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'd4);

        // R1: table of 32 entries
        load_tbl(32'h0001_0000, 16'd255);
        put_desc(8'd3,  16'h0008, 32'h1234_5678, 8'h00, 8'h8E);
        put_desc(8'd4,  16'h0010, 32'hCAFE_0001, 8'h00, 8'hE7);
        put_desc(8'd5,  16'h0028, 32'h0000_BEEF, 8'h00, 8'h95);
        put_desc(8'd6,  16'h0018, 32'h1111_2222, 8'h00, 8'h96);
        put_desc(8'd7,  16'h0018, 32'h3333_4444, 8'h00, 8'h0E);
        put_desc(8'd8,  16'h0018, 32'h5555_6666, 8'h00, 8'h8E);
        put_desc(8'd9,  16'h0018, 32'h7777_8888, 8'h00, 8'h89);
        put_desc(8'd10, 16'h0018, 32'h9999_AAAA, 8'h01, 8'h8E);
        put_desc(8'd11, 16'h0018, 32'h0, 8'h00, 8'h13);
        put_desc(8'd12, 16'h0018, 32'h0, 8'h00, 8'h1E);
        put_desc(8'd13, 16'h0018, 32'h0, 8'h00, 8'h0E);
        put_desc(8'd14, 16'h0020, 32'hFEDC_BA98, 8'h00, 8'hCF);
        put_desc(8'd15, 16'h0030, 32'h0BAD_F00D, 8'h00, 8'hA6);
        put_desc(8'd31, 16'h0040, 32'hABCD_EF01, 8'h00, 8'hEF);

        run_req(8'd3,  2'd0, "R4 R5 int32");
        run_req(8'd4,  2'd3, "R5 R9 trap16 equal ring");
        run_req(8'd5,  2'd0, "R7 task gate storage bit");
        run_req(8'd6,  2'd0, "R7 storage fault");
        run_req(8'd7,  2'd0, "R8 not present");
        run_req(8'd8,  2'd1, "R9 privilege fault");
        run_req(8'd9,  2'd0, "R6 bad type");
        run_req(8'd10, 2'd0, "R6 reserved byte");
        run_req(8'd11, 2'd3, "R10 type first");
        run_req(8'd12, 2'd3, "R10 storage before present");
        run_req(8'd13, 2'd3, "R10 present before privilege");
        run_req(8'd14, 2'd2, "R5 trap32");
        run_req(8'd15, 2'd1, "R5 int16");
        run_req(8'd31, 2'd3, "R2 last entry in limit");
        run_req(8'd32, 2'd0, "R2 first entry past limit");
        run_req(8'd200, 2'd0, "R2 far past limit");

        // R3 address wrap, R2 large limit
        load_tbl(32'hFFFF_FFF0, 16'hFFFF);
        put_desc(8'd255, 16'h0050, 32'h8000_0001, 8'h00, 8'h8F);
        put_desc(8'd2,   16'h0058, 32'h0000_1000, 8'h00, 8'h8E);
        put_desc(8'd1,   16'h0060, 32'h4321_8765, 8'h00, 8'h8E);
        run_req(8'd255, 2'd0, "R2 R3 wrapped top vector");
        run_req(8'd2,   2'd0, "R3 wrap to zero");
        run_req(8'd1,   2'd0, "R3 below wrap");

        // R1 reload: three-entry table
        load_tbl(32'h0000_2000, 16'h0017);
        put_desc(8'd2, 16'h0068, 32'h2468_ACE0, 8'h00, 8'h8E);
        put_desc(8'd3, 16'h0070, 32'h1357_9BDF, 8'h00, 8'h8E);
        run_req(8'd2, 2'd0, "R1 R2 reloaded limit edge");
        run_req(8'd3, 2'd0, "R1 R2 reloaded past limit");

        repeat (5) @(negedge clk);
        report();
    end

endmodule